// File: doc/BRIEF.md
# Five-Input Least-Recently-Granted Arbiter

This block picks one winner among five requesters each cycle and drives a one-hot grant. Fairness comes from an ordered list of five requester indices held in registers, ranked from highest to lowest priority. The arbiter walks that list from the top and grants the first requester whose request line is active. On the following clock edge the winner is taken out of the list and put at the bottom. Entries that ranked below the winner move up one place, and entries that ranked above it stay where they are. The list therefore always orders the requesters by how recently each was granted.

The grant is a combinational function of the request lines, the enable input and the current list. The list changes only on a rising clock edge after a grant has been issued. When enable is low, or no request is active, no grant is driven and the list keeps its order. A typical use is one output port of a crossbar switch, where the grant vector serves directly as the mux select.

Top module: `rank_arbiter`

## Requirements
- R1: After reset the list holds requester indices 0, 1, 2, 3, 4 from highest to lowest rank. With all five requests held active, grants go to requester 0, then 1, 2, 3, 4, and then 0 again.
- R2: The grant goes to the requester that has the highest list position among the requesters whose request bit is set. Bit i of the request input belongs to requester i.
- R3: After a grant, the winner moves to the lowest position. Entries that ranked below the winner each move up one position, and entries that ranked above it keep their positions.
- R4: At most one grant bit is set in any cycle, and a grant bit is only ever set for a requester whose request bit is set. Bit i of the grant output belongs to requester i.
- R5: When no request bit is set, no grant is issued and the list is left unchanged.
- R6: When the enable input is low, no grant is issued and the list is left unchanged, whatever the request lines show.
- R7: The grant responds to the request lines within the same cycle. The list is updated only on the rising clock edge that follows a grant.
- R8: The list always holds a permutation of the indices 0 to 4.
- R9: When enable is high and at least one request bit is set, exactly one grant bit is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; the list updates on the rising edge |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Arbitration enable |
| req_i | input | 5 | Request lines, one per requester |
| gnt_o | output | 5 | One-hot grant, or zero |

## Verification
The checker tests the rules that hold in every cycle. These are: the grant is one-hot or zero and lies within the request lines; enable low forces zero; an active request with enable high always produces a grant; the list stays a permutation; an idle cycle leaves the list unchanged; and the last winner lands in the lowest slot. Whether the grant follows true least-recently-granted order over long sequences can only be shown by the bench's scenarios. The bench compares the grants against an independent model of the list, and it confirms that a request change inside a cycle moves the grant without moving the list.

// File: rtl/rank_arb_pkg.sv
package rank_arb_pkg;
  localparam int unsigned ARB_N = 5;
  localparam int unsigned ARB_IW = (ARB_N > 1) ? $clog2(ARB_N) : 1;
endpackage

// File: rtl/rank_chain.sv
module rank_chain #(
  parameter int unsigned N  = rank_arb_pkg::ARB_N,
  parameter int unsigned IW = rank_arb_pkg::ARB_IW
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            upd_i,
  input  logic [IW-1:0]   pos_i,
  output logic [N*IW-1:0] rank_o
);
  logic [IW-1:0] rank_q [N];
  logic [IW-1:0] win_idx;

  assign win_idx = rank_q[pos_i];

  for (genvar k = 0; k < N; k++) begin : g_slot
    if (k == N - 1) begin : g_tail
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)    rank_q[k] <= IW'(k);
        else if (upd_i) rank_q[k] <= win_idx;
      end
    end else begin : g_body
      // slots at or below the winner shift up by one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                          rank_q[k] <= IW'(k);
        else if (upd_i && (IW'(k) >= pos_i))  rank_q[k] <= rank_q[k+1];
      end
    end
    assign rank_o[k*IW +: IW] = rank_q[k];
  end
endmodule

// File: rtl/rank_picker.sv
module rank_picker #(
  parameter int unsigned N  = rank_arb_pkg::ARB_N,
  parameter int unsigned IW = rank_arb_pkg::ARB_IW
) (
  input  logic            en_i,
  input  logic [N-1:0]    req_i,
  input  logic [N*IW-1:0] rank_i,
  output logic            hit_o,
  output logic [IW-1:0]   pos_o,
  output logic [N-1:0]    gnt_o
);
  logic [IW-1:0] win_idx;

  // scan lowest rank first so the highest-ranked hit wins
  always_comb begin
    hit_o = 1'b0;
    pos_o = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (req_i[rank_i[k*IW +: IW]]) begin
        hit_o = 1'b1;
        pos_o = IW'(k);
      end
    end
  end

  assign win_idx = rank_i[pos_o*IW +: IW];

  for (genvar j = 0; j < N; j++) begin : g_gnt
    assign gnt_o[j] = en_i & hit_o & (win_idx == IW'(j));
  end
endmodule

// File: rtl/rank_arbiter.sv
module rank_arbiter #(
  parameter int unsigned N  = rank_arb_pkg::ARB_N,
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [N-1:0] req_i,
  output logic [N-1:0] gnt_o
);
  logic [N*IW-1:0] rank_flat;
  logic            hit;
  logic [IW-1:0]   pos;

  rank_picker #(.N(N), .IW(IW)) u_picker (
    .en_i  (en_i),
    .req_i (req_i),
    .rank_i(rank_flat),
    .hit_o (hit),
    .pos_o (pos),
    .gnt_o (gnt_o)
  );

  rank_chain #(.N(N), .IW(IW)) u_chain (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .upd_i (en_i & hit),
    .pos_i (pos),
    .rank_o(rank_flat)
  );
endmodule

// File: rtl/rank_arb_checker.sv
module rank_arb_checker #(
  parameter int unsigned N  = 5,
  parameter int unsigned IW = 3
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            en_i,
  input logic [N-1:0]    req_i,
  input logic [N-1:0]    gnt_i,
  input logic [N*IW-1:0] rank_i
);
  logic          perm_ok;
  logic [IW-1:0] gnt_idx;

  always_comb begin
    perm_ok = 1'b1;
    for (int j = 0; j < N; j++) begin
      int cnt;
      cnt = 0;
      for (int k = 0; k < N; k++)
        if (rank_i[k*IW +: IW] == IW'(j)) cnt++;
      if (cnt != 1) perm_ok = 1'b0;
    end
    gnt_idx = '0;
    for (int j = 0; j < N; j++)
      if (gnt_i[j]) gnt_idx = IW'(j);
  end

  assert_onehot_gnt_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_i));
  assert_gnt_in_req_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_i & ~req_i) == '0);
  assert_en_low_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> gnt_i == '0);
  assert_work_conserving_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && req_i != '0) |-> $countones(gnt_i) == 1);
  assert_permutation_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    perm_ok);
  assert_idle_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_i == '0) |=> $stable(rank_i));
  assert_winner_to_tail_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_i != '0) |=> rank_i[(N-1)*IW +: IW] == $past(gnt_idx));
endmodule

bind rank_arbiter rank_arb_checker #(.N(N), .IW(IW)) u_rank_arb_checker (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .en_i  (en_i),
  .req_i (req_i),
  .gnt_i (gnt_o),
  .rank_i(rank_flat)
);

// File: tb/rank_arbiter_bench.sv
module rank_arbiter_bench;
  localparam int N = 5;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         en_i = 1'b0;
  logic [N-1:0] req_i = '0;
  logic [N-1:0] gnt_o;

  int n_run = 0;
  int n_fail = 0;
  int model [N];

  always #10 clk_i = ~clk_i;

  rank_arbiter u_rank_arbiter (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (en_i),
    .req_i (req_i),
    .gnt_o (gnt_o)
  );

  task automatic check(input bit ok, input string tag, input logic [N-1:0] act,
                       input logic [N-1:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: gnt act=%b exp=%b", tag, act, exp);
    end
  endtask

  function automatic int model_pos(input logic [N-1:0] r);
    for (int k = 0; k < N; k++) if (r[model[k]]) return k;
    return -1;
  endfunction

  function automatic logic [N-1:0] model_gnt(input logic [N-1:0] r, input logic e);
    int p;
    p = model_pos(r);
    if (!e || p < 0) return '0;
    return N'(1) << model[p];
  endfunction

  function automatic void model_update(input logic [N-1:0] r, input logic e);
    int p, w;
    p = model_pos(r);
    if (!e || p < 0) return;
    w = model[p];
    for (int k = p; k < N - 1; k++) model[k] = model[k+1];
    model[N-1] = w;
  endfunction

  task automatic step(input logic [N-1:0] r, input logic e, input string tag);
    logic [N-1:0] exp;
    @(negedge clk_i);
    req_i = r;
    en_i  = e;
    #1;
    exp = model_gnt(r, e);
    check(gnt_o === exp, tag, gnt_o, exp);
    @(posedge clk_i);
    model_update(r, e);
  endtask

  task automatic t_reset;
    rst_ni = 1'b0;
    req_i = '1;
    en_i = 1'b0;
    for (int k = 0; k < N; k++) model[k] = k;
    repeat (3) @(negedge clk_i);
    #1;
    check(gnt_o === '0, "R6 reset en low", gnt_o, '0);
    rst_ni = 1'b1;
  endtask

  task automatic t_reset_order;
    // R1: full request rotates 0,1,2,3,4,0
    for (int i = 0; i <= N; i++) begin
      logic [N-1:0] exp;
      exp = N'(1) << (i % N);
      check(model_gnt('1, 1'b1) === exp, "R1 model", model_gnt('1, 1'b1), exp);
      step('1, 1'b1, "R1 reset order");
    end
  endtask

  task automatic t_priority;
    // R2/R3: mixed patterns against list model
    step(5'b10100, 1'b1, "R2 pick 2");
    step(5'b10100, 1'b1, "R3 2 demoted, pick 4");
    step(5'b10101, 1'b1, "R2 pick 0");
    step(5'b00111, 1'b1, "R3 order");
    step(5'b01000, 1'b1, "R9 single 3");
    step(5'b11111, 1'b1, "R3 after single");
    step(5'b11111, 1'b1, "R3 chain");
  endtask

  task automatic t_idle;
    step('0, 1'b1, "R5 no request");
    step('0, 1'b1, "R5 no request");
    step('1, 1'b1, "R5 list kept");
  endtask

  task automatic t_enable;
    step(5'b11111, 1'b0, "R6 en low");
    step(5'b00110, 1'b0, "R6 en low");
    step(5'b11111, 1'b1, "R6 list kept");
  endtask

  task automatic t_comb;
    logic [N-1:0] exp;
    @(negedge clk_i);
    en_i = 1'b1;
    req_i = 5'b00100;
    #1;
    exp = model_gnt(req_i, 1'b1);
    check(gnt_o === exp, "R7 same-cycle a", gnt_o, exp);
    #3;
    req_i = 5'b10010;
    #1;
    exp = model_gnt(req_i, 1'b1);
    check(gnt_o === exp, "R7 same-cycle b", gnt_o, exp);
    @(posedge clk_i);
    model_update(req_i, 1'b1);
    step('1, 1'b1, "R7 list moved at edge");
  endtask

  task automatic t_sweep;
    // R8/R4: long pseudo-random run keeps list a valid permutation
    logic [7:0] lfsr = 8'hA5;
    for (int i = 0; i < 300; i++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      step(lfsr[4:0], lfsr[7] | lfsr[6], "R8 sweep");
    end
  endtask

  initial begin
    #(20 * 100000);
    n_fail++;
    $display("FAIL watchdog: act=running exp=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_reset_order();
    t_priority();
    t_idle();
    t_enable();
    t_comb();
    t_sweep();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule